// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps a 64-bit up-counting time base, an alternate 64-bit time base, and a 32-bit down-counting decrementer. All of them advance on a shared single-cycle `tick` enable that comes from a clock divider elsewhere. A freeze input stops both time bases and leaves the decrementer running. Software reaches the counters through a small register port. The time base is seen as two 32-bit halves. Writing one half leaves the other half as it was.

The decrementer raises an interrupt when it runs out. Two interrupt styles are selectable:

- **Edge style:** a sticky flag is set by the underflow, by certain software writes, and by a write of a very small count. A one-cycle acknowledge clears it.
- **Level style:** the interrupt simply follows the decrementer's most significant bit. Writing a value with that bit clear withdraws the request.

A saturating option makes the decrementer stop at zero instead of wrapping.

Top module: `timebase_decrementer`

## Requirements
- R1: A write to address 0 (time base bits 31:0) replaces only bits 31:0 and leaves bits 63:32 unchanged.
- R2: A write to address 1 (time base bits 63:32) replaces only bits 63:32 and leaves bits 31:0 unchanged.
- R3: While `freeze` is low, each `tick` adds one to the time base and to `alt_count`, with carry from bit 31 into bit 32.
- R4: While `freeze` is high, the time base and `alt_count` hold their values despite ticks. After release, counting resumes from the held values.
- R5: Each `tick` subtracts one from the decrementer. In non-saturating edge style, a tick taken at 0 wraps the count to 0xFFFFFFFF and sets the interrupt, which is seen on `dec_irq` after that clock edge.
- R6: In edge style, writing a decrementer value of 0 or 1 raises `dec_irq` at once, with no tick needed.
- R7: In edge style, a decrementer write that turns bit 31 from 0 to 1 raises `dec_irq`. A write where bit 31 was already 1 does not.
- R8: In level style (`level_mode`=1), `dec_irq` equals bit 31 of the decrementer one clock later. Writing a value with bit 31 clear drops the request, and `irq_ack` has no effect.
- R9: In edge style, `irq_ack` clears the pending interrupt. A new raising event in the same cycle wins over the acknowledge.
- R10: With `sat_mode`=1, a tick at 0 leaves the decrementer at 0. In edge style, the interrupt is raised by the tick that takes the count from 1 to 0.
- R11: After reset, the time base and `alt_count` are 0, the decrementer is 0xFFFFFFFF, and `dec_irq` is low in edge style.
- R12: The register port works as follows:
  - Addresses: 0 is time base bits 31:0, 1 is bits 63:32, 2 is the decrementer, and address 3 reads 0.
  - Reads: `reg_rdata` is loaded one clock after a read request and holds until the next read.
  - Write versus tick: a register written in a cycle does not also count in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one pulse per time base period |
| freeze | input | 1 | High stops both time bases |
| level_mode | input | 1 | 1: interrupt follows decrementer bit 31; 0: sticky edge flag |
| sat_mode | input | 1 | 1: decrementer stops at zero |
| irq_ack | input | 1 | One-cycle acknowledge of the edge-style interrupt |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 write, 0 read |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| alt_count | output | 64 | Alternate time base value |
| dec_irq | output | 1 | Decrementer interrupt request |

## Verification
The time base is driven with plain tick runs, runs that carry across the half boundary after a low-half write, and tick runs under freeze. These separate true half-preserving writes from whole-word writes, and separate a frozen count from a lost one. The decrementer is taken through several kinds of stimulus:

- a natural underflow, and writes of 0 and 1;
- writes that do and do not flip bit 31;
- the saturating path.

Together these distinguish each raising cause in edge style from the bit-31 tracking of level style. Acknowledge pulses are placed alone and together with a wrap, which exposes the priority of set over clear.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  typedef enum logic [1:0] {
    RA_TB_LO = 2'd0,
    RA_TB_HI = 2'd1,
    RA_DEC   = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tbd_counter.sv
module tbd_counter #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr_lo) begin
      count[HALF_W-1:0] <= wdata;
    end else if (wr_hi) begin
      count[CNT_W-1:HALF_W] <= wdata;
    end else if (run) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/tbd_decr.sv
module tbd_decr #(
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sat,
  input  logic             wr,
  input  logic [DEC_W-1:0] wdata,
  output logic [DEC_W-1:0] value,
  output logic             msb_nxt,
  output logic             wrap_evt,
  output logic             wr_raise
);
  localparam logic [DEC_W-1:0] ONE = DEC_W'(1);
  logic [DEC_W-1:0] nxt;

  always_comb begin
    nxt = value;
    if (wr) begin
      nxt = wdata;
    end else if (tick) begin
      if (sat && value == '0) nxt = value;
      else                    nxt = value - ONE;
    end
  end

  assign msb_nxt  = nxt[DEC_W-1];
  assign wrap_evt = !wr && tick && (sat ? (value == ONE) : (value == '0));
  assign wr_raise = wr && ((wdata <= ONE) || (wdata[DEC_W-1] && !value[DEC_W-1]));

  always_ff @(posedge clk) begin
    if (rst) value <= '1;
    else     value <= nxt;
  end
endmodule

// File: rtl/tbd_irq_ctl.sv
module tbd_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic ack,
  input  logic wrap_evt,
  input  logic wr_raise,
  input  logic msb_nxt,
  output logic irq
);
  logic flag_q, flag_nxt;

  always_comb begin
    if (level) flag_nxt = 1'b0;
    else       flag_nxt = wrap_evt | wr_raise | (flag_q & ~ack);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq    <= level ? msb_nxt : flag_nxt;
    end
  end
endmodule

// File: rtl/timebase_decrementer.sv
module timebase_decrementer #(
  parameter int DATA_W = 32,
  localparam int TB_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              freeze,
  input  logic              level_mode,
  input  logic              sat_mode,
  input  logic              irq_ack,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [TB_W-1:0]   alt_count,
  output logic              dec_irq
);
  import tbd_pkg::*;

  localparam int N_TB = 2;

  logic wr_lo, wr_hi, wr_dec, rd_req;
  logic tb_run;
  logic [TB_W-1:0] tb_cnt [N_TB];
  logic [TB_W-1:0] tb_main;
  logic [DATA_W-1:0] dec_val;
  logic dec_msb_nxt, dec_wrap, dec_wr_raise;
  logic [DATA_W-1:0] rd_mux;

  assign wr_lo  = reg_valid && reg_write && (reg_addr == RA_TB_LO);
  assign wr_hi  = reg_valid && reg_write && (reg_addr == RA_TB_HI);
  assign wr_dec = reg_valid && reg_write && (reg_addr == RA_DEC);
  assign rd_req = reg_valid && !reg_write;
  assign tb_run = tick && !freeze;

  // index 0: software-visible time base, index 1: alternate time base
  for (genvar g = 0; g < N_TB; g++) begin : g_tb
    tbd_counter #(.HALF_W(DATA_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .run   (tb_run),
      .wr_lo (g == 0 ? wr_lo : 1'b0),
      .wr_hi (g == 0 ? wr_hi : 1'b0),
      .wdata (reg_wdata),
      .count (tb_cnt[g])
    );
  end

  assign tb_main   = tb_cnt[0];
  assign alt_count = tb_cnt[1];

  tbd_decr #(.DEC_W(DATA_W)) u_decr (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .sat      (sat_mode),
    .wr       (wr_dec),
    .wdata    (reg_wdata),
    .value    (dec_val),
    .msb_nxt  (dec_msb_nxt),
    .wrap_evt (dec_wrap),
    .wr_raise (dec_wr_raise)
  );

  tbd_irq_ctl u_irq (
    .clk      (clk),
    .rst      (rst),
    .level    (level_mode),
    .ack      (irq_ack),
    .wrap_evt (dec_wrap),
    .wr_raise (dec_wr_raise),
    .msb_nxt  (dec_msb_nxt),
    .irq      (dec_irq)
  );

  always_comb begin
    case (reg_addr)
      RA_TB_LO: rd_mux = tb_main[DATA_W-1:0];
      RA_TB_HI: rd_mux = tb_main[TB_W-1:DATA_W];
      RA_DEC:   rd_mux = dec_val;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (rd_req) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/tbd_checker.sv
module tbd_checker #(
  parameter int DATA_W = 32,
  localparam int TB_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              freeze,
  input logic              level_mode,
  input logic              sat_mode,
  input logic              irq_ack,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [1:0]        reg_addr,
  input logic [TB_W-1:0]   tb_q,
  input logic [TB_W-1:0]   alt_q,
  input logic [DATA_W-1:0] dec_q,
  input logic              dec_irq
);
  logic dwr;
  assign dwr = reg_valid && reg_write && (reg_addr == 2'd2);

  AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && reg_write && reg_addr == 2'd0) |=> tb_q[TB_W-1:DATA_W] == $past(tb_q[TB_W-1:DATA_W])); // R1
  AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && reg_write && reg_addr == 2'd1) |=> tb_q[DATA_W-1:0] == $past(tb_q[DATA_W-1:0])); // R2
  AST_ALT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (tick && !freeze) |=> alt_q == $past(alt_q) + 64'd1); // R3
  AST_FREEZE_HOLDS_ALT: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(alt_q)); // R4
  AST_LEVEL_TRACKS_MSB: assert property (@(posedge clk) disable iff (rst)
    level_mode |=> dec_irq == dec_q[DATA_W-1]); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && irq_ack && !tick && !dwr) |=> !dec_irq); // R9
  AST_SAT_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sat_mode && tick && !dwr && dec_q == '0) |=> dec_q == '0); // R10
endmodule

bind timebase_decrementer tbd_checker #(.DATA_W(DATA_W)) u_tbd_checker (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .freeze     (freeze),
  .level_mode (level_mode),
  .sat_mode   (sat_mode),
  .irq_ack    (irq_ack),
  .reg_valid  (reg_valid),
  .reg_write  (reg_write),
  .reg_addr   (reg_addr),
  .tb_q       (tb_main),
  .alt_q      (alt_count),
  .dec_q      (dec_val),
  .dec_irq    (dec_irq)
);

// File: tb/tb_timebase_decrementer.sv
module tb_timebase_decrementer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, freeze = 1'b0, level_mode = 1'b0, sat_mode = 1'b0, irq_ack = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] alt_count;
  logic        dec_irq;

  int n_chk = 0, n_fail = 0;
  logic [63:0] alt_exp = '0;

  always #(CLK_P/2) clk = ~clk;

  timebase_decrementer dut (
    .clk(clk), .rst(rst), .tick(tick), .freeze(freeze), .level_mode(level_mode),
    .sat_mode(sat_mode), .irq_ack(irq_ack), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alt_count(alt_count), .dec_irq(dec_irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (!freeze) alt_exp++;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, bit with_tick);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d; tick = with_tick;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; tick = 1'b0;
    if (with_tick && !freeze) alt_exp++;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [31:0] exp);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    chk(req, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  task automatic ack(bit with_tick);
    @(negedge clk); irq_ack = 1'b1; tick = with_tick;
    @(negedge clk); irq_ack = 1'b0; tick = 1'b0;
    if (with_tick && !freeze) alt_exp++;
  endtask

  task automatic t_reset;
    chk("R11 irq after reset", {63'h0, dec_irq}, 64'h0);
    chk("R11 alt after reset", alt_count, 64'h0);
    rd(2'd0, "R11 tb lo after reset", 32'h0);
    rd(2'd1, "R11 tb hi after reset", 32'h0);
    rd(2'd2, "R11 dec after reset", 32'hFFFF_FFFF);
  endtask

  task automatic t_count;
    ticks(5);
    rd(2'd0, "R3 tb lo after 5 ticks", 32'd5);
    chk("R3 alt after 5 ticks", alt_count, alt_exp);
    rd(2'd2, "R5 dec after 5 ticks", 32'hFFFF_FFFA);
  endtask

  task automatic t_halves;
    wr(2'd1, 32'h1234_5678, 1'b0);
    rd(2'd0, "R2 lo kept by hi write", 32'd5);
    wr(2'd0, 32'hFFFF_FFFE, 1'b0);
    rd(2'd1, "R1 hi kept by lo write", 32'h1234_5678);
    ticks(3);
    rd(2'd0, "R3 lo after carry", 32'h0000_0001);
    rd(2'd1, "R3 hi after carry", 32'h1234_5679);
    chk("R3 alt untouched by writes", alt_count, alt_exp);
  endtask

  task automatic t_freeze;
    logic [63:0] held;
    held = alt_exp;
    freeze = 1'b1;
    ticks(4);
    rd(2'd0, "R4 tb frozen", 32'h0000_0001);
    chk("R4 alt frozen", alt_count, held);
    freeze = 1'b0;
    ticks(2);
    rd(2'd0, "R4 tb resumed", 32'h0000_0003);
    chk("R4 alt resumed", alt_count, held + 64'd2);
  endtask

  task automatic t_port;
    wr(2'd2, 32'd10, 1'b1);
    rd(2'd2, "R12 write wins over tick", 32'd10);
    rd(2'd0, "R12 tb still ticks on dec write", 32'h0000_0004);
    chk("R12 alt on dec write", alt_count, alt_exp);
    rd(2'd3, "R12 unused address", 32'h0);
  endtask

  task automatic t_underflow;
    ack(1'b0);
    wr(2'd2, 32'd2, 1'b0);
    chk("R5 no irq on write 2", {63'h0, dec_irq}, 64'h0);
    ticks(2);
    chk("R5 no irq at zero", {63'h0, dec_irq}, 64'h0);
    ticks(1);
    chk("R5 irq on wrap", {63'h0, dec_irq}, 64'h1);
    rd(2'd2, "R5 wrapped value", 32'hFFFF_FFFF);
    ack(1'b0);
    chk("R9 ack clears", {63'h0, dec_irq}, 64'h0);
  endtask

  task automatic t_small_write;
    wr(2'd2, 32'd1, 1'b0);
    chk("R6 write 1 raises", {63'h0, dec_irq}, 64'h1);
    ack(1'b0);
    wr(2'd2, 32'd0, 1'b0);
    chk("R6 write 0 raises", {63'h0, dec_irq}, 64'h1);
    ack(1'b0);
    chk("R9 ack clears after write", {63'h0, dec_irq}, 64'h0);
    ack(1'b1);
    chk("R9 wrap beats ack", {63'h0, dec_irq}, 64'h1);
    ack(1'b0);
  endtask

  task automatic t_msb_write;
    wr(2'd2, 32'd5, 1'b0);
    chk("R7 no raise on write 5", {63'h0, dec_irq}, 64'h0);
    wr(2'd2, 32'h8000_0000, 1'b0);
    chk("R7 msb 0 to 1 raises", {63'h0, dec_irq}, 64'h1);
    ack(1'b0);
    wr(2'd2, 32'h9000_0000, 1'b0);
    chk("R7 msb already set, no raise", {63'h0, dec_irq}, 64'h0);
  endtask

  task automatic t_level;
    level_mode = 1'b1;
    wr(2'd2, 32'h8000_0010, 1'b0);
    chk("R8 msb set pending", {63'h0, dec_irq}, 64'h1);
    ack(1'b0);
    chk("R8 ack ignored", {63'h0, dec_irq}, 64'h1);
    wr(2'd2, 32'h0000_0010, 1'b0);
    chk("R8 msb clear drops", {63'h0, dec_irq}, 64'h0);
    wr(2'd2, 32'h0, 1'b0);
    chk("R8 write 0 not pending", {63'h0, dec_irq}, 64'h0);
    ticks(1);
    chk("R8 wrap sets msb", {63'h0, dec_irq}, 64'h1);
    level_mode = 1'b0;
    @(negedge clk);
    chk("R8 back to edge style", {63'h0, dec_irq}, 64'h0);
  endtask

  task automatic t_sat;
    sat_mode = 1'b1;
    wr(2'd2, 32'd3, 1'b0);
    chk("R10 no raise on write 3", {63'h0, dec_irq}, 64'h0);
    ticks(2);
    chk("R10 no irq at 1", {63'h0, dec_irq}, 64'h0);
    ticks(1);
    chk("R10 irq on reaching 0", {63'h0, dec_irq}, 64'h1);
    ticks(2);
    rd(2'd2, "R10 held at zero", 32'h0);
    ack(1'b0);
    ticks(1);
    chk("R10 no repeat at zero", {63'h0, dec_irq}, 64'h0);
    rd(2'd2, "R10 still zero", 32'h0);
    sat_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_halves();
    t_freeze();
    t_port();
    t_underflow();
    t_small_write();
    t_msb_write();
    t_level();
    t_sat();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule